// File: doc/BRIEF.md
# Edge-Captured Parallel Input Port

This block is one 8-bit general-purpose port of a peripheral interface adapter. A processor reaches it over a small register bus. Through that bus it sets the direction of each pin, drives the output register and reads the port. An input latch can freeze the pin levels when an active edge arrives on a strobe line (`strb_in`). The same edge raises an interrupt flag. The interrupt request output is asserted while that flag is set and interrupts are enabled.

The latch is not always in use. It holds a captured value only while latching is enabled **and** the flag is set. At every other time the port reads the live pins. A state machine with two states tracks this:
- `ST_OPEN`: the flag is clear and reads are transparent.
- `ST_HELD`: the flag is set and the captured byte is kept.

It has three transitions:
- *capture*: `ST_OPEN` to `ST_HELD`, taken on an active strobe edge. It loads the latch.
- *release*: `ST_HELD` to `ST_OPEN`, taken on a data-register access or on a write of 1 to the flag bit.
- *recapture*: `ST_HELD` to `ST_HELD`, taken when a release and an active edge fall in the same cycle. The latch reloads.

A plain active edge while in `ST_HELD` keeps the old latch contents.

Top module: `edge_latch_port`

## Requirements
- R1: After reset, the direction register, output register, control register (bit0 latch enable, bit1 edge select, bit2 interrupt enable) and flag register (bit0) all read 0, and `irq` is low.
- R2: With latch enable 0, a read of the data register (address 0) returns the live input pin levels for input-direction bits, even if the flag is set.
- R3: With latch enable 1 and the flag clear, a data read returns live pin levels.
- R4: The strobe passes through two synchroniser flops. An active edge then sets the flag (address 3, bit0) and captures the pins present in the cycle the edge is detected.
- R5: While latch enable and the flag are both 1, a data read returns the captured byte for input bits, whatever the pins do afterwards.
- R6: A data read clears the flag. The next data read returns live pins.
- R7: Writing address 3 with bit0 = 1 clears the flag. Writing bit0 = 0 leaves it set.
- R8: Direction bit 1 makes a pin an output. `pin_out` carries the output register and `pin_oe` carries the direction register. With READ_OUT_REG = 1, output bits read back from the output register.
- R9: Edge select 1 makes a rising strobe active, and edge select 0 makes a falling strobe active. An edge of the other polarity has no effect.
- R10: `irq` is high exactly while the flag and the interrupt enable are both 1.
- R11: A write to the data register clears the flag and releases the latch.
- R12: An active edge while the flag is already set does not replace the captured byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, one cycle |
| wr | input | 1 | Write strobe, one cycle |
| addr | input | 2 | Register select: 0 data, 1 direction, 2 control, 3 flag |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered, valid the cycle after the strobe |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Output register to the pads |
| pin_oe | output | 8 | Per-pin output enable (direction register) |
| strb_in | input | 1 | Asynchronous strobe line |
| irq | output | 1 | Interrupt request |

## Verification
Read data is registered. It is due on the clock edge that samples the read strobe, so the monitor compares it at the falling edge that follows. A strobe change counts as seen only after the second synchroniser flop. The capture lands one edge later, which makes it three edges after the change. The bench therefore waits four cycles after each strobe move and keeps the pins stable across that window. `irq` and the pin outputs follow their registers in the same cycle, so the bench checks them directly at falling edges.

// File: rtl/elp_pkg.sv
package elp_pkg;
    typedef enum logic {
        ST_OPEN = 1'b0,
        ST_HELD = 1'b1
    } cap_state_t;

    localparam logic [1:0] ADR_DATA = 2'd0;
    localparam logic [1:0] ADR_DIR  = 2'd1;
    localparam logic [1:0] ADR_CTRL = 2'd2;
    localparam logic [1:0] ADR_FLAG = 2'd3;

    localparam int CTRL_LEN = 0;
    localparam int CTRL_POL = 1;
    localparam int CTRL_IEN = 2;
endpackage

// File: rtl/elp_edge_sync.sv
module elp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    input  logic rise_sel,
    output logic edge_hit
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    always_comb begin
        if (rise_sel) edge_hit = sync_q[STAGES-1] & ~prev_q;
        else          edge_hit = ~sync_q[STAGES-1] & prev_q;
    end

    assert_edge_polarity_R9: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |-> (sync_q[STAGES-1] == rise_sel));
endmodule

// File: rtl/elp_capture_fsm.sv
module elp_capture_fsm
    import elp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         edge_hit,
    input  logic         release_req,
    input  logic [W-1:0] pins,
    output logic         flag,
    output logic [W-1:0] latch_val
);
    cap_state_t     state_q, state_d;
    logic [W-1:0]   latch_q;
    logic           load;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                if (edge_hit) begin
                    state_d = ST_HELD;
                    load    = 1'b1;
                end
            end
            ST_HELD: begin
                if (release_req && edge_hit) begin
                    state_d = ST_HELD;
                    load    = 1'b1;
                end else if (release_req) begin
                    state_d = ST_OPEN;
                end
            end
            default: state_d = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    latch_q <= '0;
        else if (load) latch_q <= pins;
    end

    always_comb begin
        flag      = (state_q == ST_HELD);
        latch_val = latch_q;
    end

    assert_edge_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> flag);
    assert_latch_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !release_req) |=> $stable(latch_q));
    assert_release_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (release_req && !edge_hit) |=> !flag);
endmodule

// File: rtl/elp_regs.sv
module elp_regs
    import elp_pkg::*;
#(
    parameter int W            = 8,
    parameter bit READ_OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs,
    input  logic         rd,
    input  logic         wr,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pins,
    input  logic         flag,
    input  logic [W-1:0] latch_val,
    output logic [W-1:0] rdata,
    output logic [W-1:0] out_q,
    output logic [W-1:0] dir_q,
    output logic         lat_en,
    output logic         rise_sel,
    output logic         irq_en,
    output logic         release_req
);
    logic [W-1:0] rdata_q;
    logic [W-1:0] port_view;
    logic [W-1:0] rd_mux;
    logic         acc_data;
    logic         flag_wr1;

    always_comb begin
        acc_data    = cs && (rd || wr) && (addr == ADR_DATA);
        flag_wr1    = cs && wr && (addr == ADR_FLAG) && wdata[0];
        release_req = acc_data || flag_wr1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q    <= '0;
            dir_q    <= '0;
            lat_en   <= 1'b0;
            rise_sel <= 1'b0;
            irq_en   <= 1'b0;
        end else if (cs && wr) begin
            unique case (addr)
                ADR_DATA: out_q <= wdata;
                ADR_DIR:  dir_q <= wdata;
                ADR_CTRL: begin
                    lat_en   <= wdata[CTRL_LEN];
                    rise_sel <= wdata[CTRL_POL];
                    irq_en   <= wdata[CTRL_IEN];
                end
                default: ;
            endcase
        end
    end

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic in_src;
            assign in_src = (lat_en && flag) ? latch_val[b] : pins[b];
            if (READ_OUT_REG) begin : g_outreg
                assign port_view[b] = dir_q[b] ? out_q[b] : in_src;
            end else begin : g_outpin
                assign port_view[b] = dir_q[b] ? pins[b] : in_src;
            end
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        unique case (addr)
            ADR_DATA: rd_mux = port_view;
            ADR_DIR:  rd_mux = dir_q;
            ADR_CTRL: begin
                rd_mux[CTRL_LEN] = lat_en;
                rd_mux[CTRL_POL] = rise_sel;
                rd_mux[CTRL_IEN] = irq_en;
            end
            ADR_FLAG: rd_mux[0] = flag;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        rdata_q <= '0;
        else if (cs && rd) rdata_q <= rd_mux;
    end

    assign rdata = rdata_q;

    assert_flag_write0_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && cs && wr && addr == ADR_FLAG && !wdata[0]) |=> flag);
endmodule

// File: rtl/edge_latch_port.sv
module edge_latch_port #(
    parameter int W            = 8,
    parameter int SYNC_STAGES  = 2,
    parameter bit READ_OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs,
    input  logic         rd,
    input  logic         wr,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    input  logic         strb_in,
    output logic         irq
);
    logic         edge_hit;
    logic         release_req;
    logic         flag;
    logic [W-1:0] latch_val;
    logic         lat_en;
    logic         rise_sel;
    logic         irq_en;

    elp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (strb_in),
        .rise_sel (rise_sel),
        .edge_hit (edge_hit)
    );

    elp_capture_fsm #(.W(W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_hit    (edge_hit),
        .release_req (release_req),
        .pins        (pin_in),
        .flag        (flag),
        .latch_val   (latch_val)
    );

    elp_regs #(.W(W), .READ_OUT_REG(READ_OUT_REG)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs          (cs),
        .rd          (rd),
        .wr          (wr),
        .addr        (addr),
        .wdata       (wdata),
        .pins        (pin_in),
        .flag        (flag),
        .latch_val   (latch_val),
        .rdata       (rdata),
        .out_q       (pin_out),
        .dir_q       (pin_oe),
        .lat_en      (lat_en),
        .rise_sel    (rise_sel),
        .irq_en      (irq_en),
        .release_req (release_req)
    );

    assign irq = flag && irq_en;

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |-> !irq);
endmodule

// File: tb/test_edge_latch_port.sv
`timescale 1ns/1ps
module test_edge_latch_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pin_in = 8'hA5;
    logic [7:0] pin_out, pin_oe;
    logic       strb_in = 1'b0;
    logic       irq;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_d = 1'b0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    edge_latch_port i_edge_latch_port (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .strb_in(strb_in), .irq(irq)
    );

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) rd_d <= cs & rd;

    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) begin
                check8(rdata, 8'hxx, "unexpected read");
            end else begin
                check8(rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        cs = 1'b1; rd = 1'b1; addr = a;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic strobe(input logic v);
        @(negedge clk);
        strb_in = v;
        idle(4);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        rd_reg(2'd1, 8'h00, "R1 dir");
        rd_reg(2'd2, 8'h00, "R1 ctrl");
        rd_reg(2'd3, 8'h00, "R1 flag");
        check8({7'b0, irq}, 8'h00, "R1 irq");
        check8(pin_oe, 8'h00, "R1 pin_oe");
        // R2 live pins with latching off
        rd_reg(2'd0, 8'hA5, "R2 live");
        // R3 latch enabled, rising edge select, no edge yet
        wr_reg(2'd2, 8'h03);
        rd_reg(2'd0, 8'hA5, "R3 live");
        pin_in = 8'h3C;
        rd_reg(2'd0, 8'h3C, "R3 live after change");
        // R4 capture on rising edge
        pin_in = 8'h5A;
        strobe(1'b1);
        rd_reg(2'd3, 8'h01, "R4 flag set");
        // R5 hold, then R6 release by the read
        pin_in = 8'hC3;
        rd_reg(2'd0, 8'h5A, "R5 held");
        rd_reg(2'd0, 8'hC3, "R6 live after read");
        rd_reg(2'd3, 8'h00, "R6 flag clear");
        // R9 falling edge with rising select does nothing
        strobe(1'b0);
        rd_reg(2'd3, 8'h00, "R9 wrong polarity");
        // R12 second edge does not recapture
        pin_in = 8'h11;
        strobe(1'b1);
        strobe(1'b0);
        pin_in = 8'h22;
        strobe(1'b1);
        rd_reg(2'd0, 8'h11, "R12 first capture kept");
        // R7 flag clear by write-one
        pin_in = 8'h33;
        strobe(1'b0);
        strobe(1'b1);
        pin_in = 8'h44;
        wr_reg(2'd3, 8'h00);
        rd_reg(2'd3, 8'h01, "R7 write 0 keeps flag");
        wr_reg(2'd3, 8'h01);
        rd_reg(2'd3, 8'h00, "R7 write 1 clears");
        rd_reg(2'd0, 8'h44, "R7 live after clear");
        // R11 data write clears
        pin_in = 8'h55;
        strobe(1'b0);
        strobe(1'b1);
        pin_in = 8'h66;
        wr_reg(2'd0, 8'h0F);
        rd_reg(2'd3, 8'h00, "R11 flag cleared by write");
        rd_reg(2'd0, 8'h66, "R11 live");
        // R8 direction and output readback
        wr_reg(2'd1, 8'hF0);
        @(negedge clk);
        check8(pin_out, 8'h0F, "R8 pin_out");
        check8(pin_oe, 8'hF0, "R8 pin_oe");
        rd_reg(2'd0, 8'h06, "R8 mixed read");
        // R9 falling select, R10 irq
        wr_reg(2'd2, 8'h05);
        pin_in = 8'h99;
        strobe(1'b0);
        check8({7'b0, irq}, 8'h01, "R10 irq high");
        pin_in = 8'h77;
        rd_reg(2'd0, 8'h09, "R9 falling capture");
        check8({7'b0, irq}, 8'h00, "R10 irq low after clear");
        // R10 irq masked, R2 flag set but latching off
        wr_reg(2'd2, 8'h01);
        strobe(1'b1);
        strobe(1'b0);
        check8({7'b0, irq}, 8'h00, "R10 irq masked");
        wr_reg(2'd2, 8'h00);
        rd_reg(2'd3, 8'h01, "R2 flag still set");
        rd_reg(2'd0, 8'h07, "R2 live with flag set");
        idle(3);
        if (exp_q.size() != 0) check8(8'(exp_q.size()), 8'h00, "pending reads");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule